// File: doc/BRIEF.md
# Command and Reply FIFO Register Block

This block is the device-side register window of a storage controller's host interface. A host reaches it over a plain 32-bit memory-mapped bus with separate read and write strobes. Writing the request port queues a command bus address into an inbound FIFO, which the controller core drains through a pop port. The core posts completion tags into an outbound FIFO through a push port, and the host collects them by reading the reply port.

Beside the two queues, the window holds four more registers. An interrupt status register shows whether completions are waiting and whether a command was lost. An interrupt mask register has inverted polarity: a clear bit lets the interrupt through. A scratchpad register tells the host when the firmware is ready. A doorbell register turns each host write into a one-cycle strobe toward the core. Both FIFOs are on-chip, 16 entries deep by default, and share one clock.

Top module: `cqr_host_regs`

## Requirements
- R1: A write to offset 0x40 queues the written word in the inbound FIFO. The core sees the oldest queued word on `cmd_addr` while `cmd_valid` is high, and `cmd_pop` removes it, so words leave in the order they were written.
- R2: A read of offset 0x44 with replies waiting returns the oldest reply tag on `bus_rdata` in the cycle after the read strobe, and removes that tag.
- R3: A read of offset 0x44 with no reply waiting returns 0xFFFFFFFF and changes no state.
- R4: A read of offset 0x30 returns bit 3 set exactly while the outbound FIFO holds at least one entry.
- R5: Only bit 3 of the mask register at offset 0x34 is stored. Writing it as 0 unmasks the interrupt and writing 0x08 masks it. It resets to masked, and reads back as 0x08 or 0. `irq` is high exactly while a reply is waiting and the mask bit is clear.
- R6: A read of offset 0xB0 returns 0xFFFF0000 while `fw_ready` is high, and 0 otherwise.
- R7: A request-port write while the inbound FIFO is full is discarded and sets a sticky overflow flag. The flag reads as bit 1 of offset 0x30 and is cleared only by reset.
- R8: Reads of any offset other than 0x30, 0x34, 0x44 and 0xB0 return 0, and writes to offsets other than 0x20, 0x34 and 0x40 change nothing.
- R9: A write to offset 0x20 drives `doorbell_pulse` high for exactly one cycle after the write strobe, with the written word on `doorbell_bits`.
- R10: Each FIFO holds 16 entries. `rpl_full` is high while the outbound FIFO holds 16 entries, and a core push at that time is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Reply interrupt |
| doorbell_pulse | output | 1 | One-cycle doorbell strobe |
| doorbell_bits | output | 32 | Word written to the doorbell |
| fw_ready | input | 1 | Firmware ready indication from the core |
| cmd_valid | output | 1 | Inbound FIFO holds a command |
| cmd_addr | output | 32 | Oldest command address |
| cmd_pop | input | 1 | Core removes the oldest command |
| rpl_push | input | 1 | Core posts a reply tag |
| rpl_tag | input | 32 | Reply tag to post |
| rpl_full | output | 1 | Outbound FIFO is full |

## Verification
Read data is registered once, so every reply, status, mask and scratchpad value is sampled on the falling edge that follows the rising edge that took the read strobe. FIFO pushes and pops from either side, mask writes and doorbell writes all take effect at one rising edge. `cmd_valid`, `cmd_addr`, `rpl_full`, `irq` and the doorbell strobe are therefore checked half a cycle after that edge. The doorbell strobe is checked again one cycle later to confirm that it lasts exactly one cycle. The bench applies every stimulus on a falling edge and reads results only on falling edges, so no check races the clock edge.

// File: rtl/cqr_pkg.sv
package cqr_pkg;

    localparam int WORD_W = 32;

    // Register offsets; the host software depends on these positions.
    localparam logic [7:0] OFS_DOORBELL = 8'h20;
    localparam logic [7:0] OFS_STATUS   = 8'h30;
    localparam logic [7:0] OFS_MASK     = 8'h34;
    localparam logic [7:0] OFS_REQUEST  = 8'h40;
    localparam logic [7:0] OFS_REPLY    = 8'h44;
    localparam logic [7:0] OFS_SCRATCH  = 8'hB0;

    localparam int PEND_BIT = 3;
    localparam int OVF_BIT  = 1;
    localparam int MASK_BIT = 3;

    localparam logic [WORD_W-1:0] EMPTY_WORD = '1;
    localparam logic [WORD_W-1:0] READY_WORD = 32'hFFFF_0000;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic              db_pulse;
        logic [WORD_W-1:0] db_bits;
        logic              ovf;
    } regs_state_t;

endpackage

// File: rtl/cqr_fifo.sv
module cqr_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign full     = (st_q.count == CW'(DEPTH));
    assign empty    = (st_q.count == '0);
    assign push_ok  = push && !full;
    assign pop_ok   = pop && !empty;
    assign pop_data = mem_q[st_q.rptr];

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.wptr = (st_q.wptr == AW'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rptr = (st_q.rptr == AW'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wptr] <= push_data;
    end

    // R10: occupancy never exceeds the depth
    a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH));

    // R7 / R10: a push into a full queue without a pop leaves it full and unchanged
    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(st_q.wptr)));

    // R3: popping an empty queue does nothing
    a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (empty && $stable(st_q.rptr)));

endmodule

// File: rtl/cqr_irq.sv
module cqr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic mask_wr,
    input  logic mask_bit_in,
    input  logic pending,
    output logic mask_q,
    output logic irq
);
    logic mask_d;

    always_comb begin
        mask_d = mask_q;
        if (mask_wr) mask_d = mask_bit_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= 1'b1;
        else        mask_q <= mask_d;
    end

    assign irq = pending && !mask_q;

    // R5: writing a clear bit unmasks on the next cycle
    a_r5_unmask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !mask_bit_in) |=> !mask_q);

    // R5: writing a set bit masks on the next cycle
    a_r5_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_bit_in) |=> mask_q);

endmodule

// File: rtl/cqr_host_regs.sv
module cqr_host_regs
    import cqr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_rd_en,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq,
    output logic              doorbell_pulse,
    output logic [WORD_W-1:0] doorbell_bits,
    input  logic              fw_ready,
    output logic              cmd_valid,
    output logic [WORD_W-1:0] cmd_addr,
    input  logic              cmd_pop,
    input  logic              rpl_push,
    input  logic [WORD_W-1:0] rpl_tag,
    output logic              rpl_full
);
    regs_state_t st_d, st_q;

    logic hit_db, hit_status, hit_mask, hit_req, hit_rpl, hit_scratch;
    logic wr_req, wr_mask, wr_db, rd_rpl;
    logic in_full, in_empty, out_empty;
    logic [WORD_W-1:0] rpl_head;
    logic mask_q;

    assign hit_db      = (bus_addr == ADDR_W'(OFS_DOORBELL));
    assign hit_status  = (bus_addr == ADDR_W'(OFS_STATUS));
    assign hit_mask    = (bus_addr == ADDR_W'(OFS_MASK));
    assign hit_req     = (bus_addr == ADDR_W'(OFS_REQUEST));
    assign hit_rpl     = (bus_addr == ADDR_W'(OFS_REPLY));
    assign hit_scratch = (bus_addr == ADDR_W'(OFS_SCRATCH));

    assign wr_req  = bus_wr_en && hit_req;
    assign wr_mask = bus_wr_en && hit_mask;
    assign wr_db   = bus_wr_en && hit_db;
    assign rd_rpl  = bus_rd_en && hit_rpl;

    cqr_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_cmd_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_req),
        .push_data (bus_wdata),
        .pop       (cmd_pop),
        .pop_data  (cmd_addr),
        .full      (in_full),
        .empty     (in_empty)
    );

    cqr_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rpl_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rpl_push),
        .push_data (rpl_tag),
        .pop       (rd_rpl),
        .pop_data  (rpl_head),
        .full      (rpl_full),
        .empty     (out_empty)
    );

    cqr_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_wr     (wr_mask),
        .mask_bit_in (bus_wdata[MASK_BIT]),
        .pending     (!out_empty),
        .mask_q      (mask_q),
        .irq         (irq)
    );

    assign cmd_valid = !in_empty;

    always_comb begin
        st_d          = st_q;
        st_d.db_pulse = 1'b0;
        if (wr_db) begin
            st_d.db_pulse = 1'b1;
            st_d.db_bits  = bus_wdata;
        end
        if (wr_req && in_full) begin
            st_d.ovf = 1'b1;
        end
        if (bus_rd_en) begin
            st_d.rdata = '0;
            if (hit_status) begin
                st_d.rdata[PEND_BIT] = !out_empty;
                st_d.rdata[OVF_BIT]  = st_q.ovf;
            end else if (hit_mask) begin
                st_d.rdata[MASK_BIT] = mask_q;
            end else if (hit_rpl) begin
                st_d.rdata = out_empty ? EMPTY_WORD : rpl_head;
            end else if (hit_scratch) begin
                st_d.rdata = fw_ready ? READY_WORD : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata      = st_q.rdata;
    assign doorbell_pulse = st_q.db_pulse;
    assign doorbell_bits  = st_q.db_bits;

    // R3: an empty reply read returns all ones
    a_r3_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rpl && out_empty) |=> (bus_rdata == EMPTY_WORD));

    // R5: the interrupt only rises with a reply waiting
    a_r5_irq_needs_reply: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !out_empty);

    // R7: overflow flag is sticky
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);

    // R9: a doorbell write yields one strobe carrying the written word
    a_r9_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
        wr_db |=> (doorbell_pulse && doorbell_bits == $past(bus_wdata)));

    // R9: the strobe never lasts two cycles without a second write
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (doorbell_pulse && !wr_db) |=> !doorbell_pulse);

endmodule

// File: tb/cqr_host_regs_tb.sv
`timescale 1ns/1ps
module cqr_host_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq, doorbell_pulse, cmd_valid, rpl_full;
    logic [31:0] doorbell_bits, cmd_addr;
    logic        fw_ready = 1'b0;
    logic        cmd_pop = 1'b0;
    logic        rpl_push = 1'b0;
    logic [31:0] rpl_tag = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cqr_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
        .irq(irq), .doorbell_pulse(doorbell_pulse), .doorbell_bits(doorbell_bits),
        .fw_ready(fw_ready), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_pop(cmd_pop), .rpl_push(rpl_push), .rpl_tag(rpl_tag), .rpl_full(rpl_full)
    );

    // Vector: {is_read, offset, data}; data is write data or expected read data.
    localparam int NVEC = 11;
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b1, 8'h30, 32'h0000_0000},   // R4 nothing pending
        {1'b1, 8'h34, 32'h0000_0008},   // R5 reset masked
        {1'b1, 8'hB0, 32'hFFFF_0000},   // R6 ready
        {1'b1, 8'h44, 32'hFFFF_FFFF},   // R3 empty reply read
        {1'b0, 8'h34, 32'h0000_0000},   // R5 unmask
        {1'b1, 8'h34, 32'h0000_0000},   // R5
        {1'b1, 8'h10, 32'h0000_0000},   // R8 unmapped read
        {1'b0, 8'h10, 32'h1234_5678},   // R8 unmapped write
        {1'b1, 8'h10, 32'h0000_0000},   // R8
        {1'b0, 8'h34, 32'h0000_0008},   // R5 mask
        {1'b1, 8'h34, 32'h0000_0008}    // R5
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd_en = 1'b0;
    endtask

    task automatic core_push(input logic [31:0] t);
        @(negedge clk);
        rpl_tag = t; rpl_push = 1'b1;
        @(negedge clk);
        rpl_push = 1'b0;
    endtask

    task automatic core_pop();
        @(negedge clk);
        cmd_pop = 1'b1;
        @(negedge clk);
        cmd_pop = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fw_ready = 1'b1;
        @(negedge clk);

        // Reset state
        check("reset irq", {31'd0, irq}, 32'd0);
        check("reset cmd_valid", {31'd0, cmd_valid}, 32'd0);
        check("reset rpl_full", {31'd0, rpl_full}, 32'd0);
        check("reset doorbell", {31'd0, doorbell_pulse}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][40]) begin
                bus_rd(VEC[i][39:32], rd);
                check($sformatf("vector %0d off %02h", i, VEC[i][39:32]), rd, VEC[i][31:0]);
            end else begin
                bus_wr(VEC[i][39:32], VEC[i][31:0]);
            end
        end

        // R6 not ready
        fw_ready = 1'b0;
        bus_rd(8'hB0, rd);
        check("R6 not ready", rd, 32'd0);
        fw_ready = 1'b1;

        // R1 command order
        bus_wr(8'h40, 32'hC000_0001);
        bus_wr(8'h40, 32'hC000_0002);
        bus_wr(8'h40, 32'hC000_0003);
        for (int i = 1; i <= 3; i++) begin
            check("R1 cmd_valid", {31'd0, cmd_valid}, 32'd1);
            check("R1 cmd_addr order", cmd_addr, 32'hC000_0000 + 32'(i));
            core_pop();
        end
        check("R1 drained", {31'd0, cmd_valid}, 32'd0);

        // R9 doorbell
        bus_wr(8'h20, 32'h0000_00A5);
        check("R9 pulse", {31'd0, doorbell_pulse}, 32'd1);
        check("R9 bits", doorbell_bits, 32'h0000_00A5);
        @(negedge clk);
        check("R9 single cycle", {31'd0, doorbell_pulse}, 32'd0);

        // R2 R4 R5 replies with interrupt gating
        core_push(32'h0000_AA01);
        core_push(32'h0000_AA02);
        check("R5 masked irq", {31'd0, irq}, 32'd0);
        bus_rd(8'h30, rd);
        check("R4 pending", rd, 32'h0000_0008);
        bus_wr(8'h34, 32'h0000_0000);
        check("R5 unmasked irq", {31'd0, irq}, 32'd1);
        bus_rd(8'h44, rd);
        check("R2 first reply", rd, 32'h0000_AA01);
        check("R5 irq still", {31'd0, irq}, 32'd1);
        bus_rd(8'h44, rd);
        check("R2 second reply", rd, 32'h0000_AA02);
        check("R5 irq drops", {31'd0, irq}, 32'd0);
        bus_rd(8'h30, rd);
        check("R4 clear", rd, 32'd0);
        bus_rd(8'h44, rd);
        check("R3 empty again", rd, 32'hFFFF_FFFF);

        // R10 outbound depth
        for (int i = 0; i < 16; i++) core_push(32'h0000_B000 + 32'(i));
        check("R10 full", {31'd0, rpl_full}, 32'd1);
        core_push(32'h0000_DEAD);
        for (int i = 0; i < 16; i++) begin
            bus_rd(8'h44, rd);
            check("R10 reply order", rd, 32'h0000_B000 + 32'(i));
        end
        bus_rd(8'h44, rd);
        check("R10 extra push dropped", rd, 32'hFFFF_FFFF);
        check("R10 not full", {31'd0, rpl_full}, 32'd0);

        // R7 inbound overflow
        for (int i = 0; i < 17; i++) bus_wr(8'h40, 32'h0000_1000 + 32'(i));
        bus_rd(8'h30, rd);
        check("R7 overflow flag", rd, 32'h0000_0002);
        for (int i = 0; i < 16; i++) begin
            check("R7 kept entry", cmd_addr, 32'h0000_1000 + 32'(i));
            core_pop();
        end
        check("R7 extra write dropped", {31'd0, cmd_valid}, 32'd0);
        bus_rd(8'h30, rd);
        check("R7 sticky", rd, 32'h0000_0002);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule